// File: doc/BRIEF.md
# Relative Jump and Condition Unit

This unit resolves relative jumps in a small 16-bit processor core. Each cycle it takes the instruction pointer, already advanced past the jump instruction, together with the jump kind, a four-bit condition code, the immediate offset bytes and the four status flags (zero, carry, sign, overflow). It decides whether the jump is taken and produces the pointer of the next instruction to fetch.

Two jump kinds are handled. The always-taken kind carries a 16-bit signed displacement. The conditional kind carries an 8-bit displacement that is sign-extended before it is added. Conditions cover equality, carry, and unsigned and signed orderings, each with its negation, all evaluated from the flags left by an earlier compare or subtract. Both results are registered, so they are valid one clock after the inputs are presented. Opcode decode and instruction fetch sit outside the unit.

Top module: `jcu_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both outputs become zero: `taken_o` = 0 and `next_ip_o` = 0000h.
- R2: Each result is registered. Inputs present at rising edge k appear on the outputs after edge k and hold until edge k+1.
- R3: With `kind_i` = 1 (always-taken), `taken_o` is 1 and `next_ip_o` = `ip_i` + `imm_i`. `imm_i[7:0]` holds the first offset byte fetched (low byte) and `imm_i[15:8]` the second (high byte). Example: ip 0037h, bytes 10h then 00h give 0047h.
- R4: With `kind_i` = 0 (conditional), only `imm_i[7:0]` is used. It is sign-extended to 16 bits, which gives a reach of -128 to +127 bytes. `imm_i[15:8]` has no effect.
- R5: When the jump is not taken, `next_ip_o` equals `ip_i` unchanged.
- R6: The condition code is `cond_i[3:1]` with a negate bit `cond_i[0]`. Group 0 tests ZF = 1 (equal/zero). Group 1 tests CF = 1 (carry, also unsigned below).
- R7: Group 2 tests CF = 1 or ZF = 1 (unsigned below-or-equal). Its negated code 5 is unsigned above.
- R8: Group 3 tests SF != OF (signed less). Its negated code 7 is greater-or-equal. Group 4 tests ZF = 1 or SF != OF (signed less-or-equal). Its negated code 9 is signed greater.
- R9: An odd code is taken exactly when the even code below it is not taken, for codes 0 to 9.
- R10: Codes 10 to 15 are never taken under the conditional kind, for any flags.
- R11: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ip_i | input | 16 | Instruction pointer after the jump instruction |
| kind_i | input | 1 | 1 = always-taken 16-bit offset, 0 = conditional 8-bit offset |
| cond_i | input | 4 | Condition code (group in [3:1], negate in [0]) |
| imm_i | input | 16 | Offset bytes, first fetched byte in [7:0] |
| zf_i | input | 1 | Zero flag |
| cf_i | input | 1 | Carry/borrow flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| taken_o | output | 1 | Jump taken, registered |
| next_ip_o | output | 16 | Next instruction pointer, registered |

## Verification
Both outputs are due exactly one rising edge after their inputs. Every scenario task therefore drives inputs on a falling edge, waits for the next rising edge and samples 1 ns later. One check instead samples before that edge, to confirm that the previous result still holds. The condition sweep compares every code under all sixteen flag combinations with a model in the bench written from the requirement encodings. The compare of 7FFFh with 8000h gives a case where unsigned and signed ordering disagree.

// File: rtl/jcu_pkg.sv
// Shared types for the relative jump and condition unit.
// Assumes a 16-bit address space and 4-bit condition codes.
package jcu_pkg;
    localparam int ADDR_W  = 16;
    localparam int SHORT_W = 8;
    localparam int COND_W  = 4;

    // Jump kind selected by the decoder
    typedef enum logic {
        JK_SHORT_COND = 1'b0,
        JK_NEAR_ALWAYS = 1'b1
    } jump_kind_e;

    // Condition group held in cond[3:1]; cond[0] negates the group
    typedef enum logic [2:0] {
        CG_ZERO   = 3'd0,
        CG_CARRY  = 3'd1,
        CG_ULE    = 3'd2,
        CG_SLT    = 3'd3,
        CG_SLE    = 3'd4
    } cond_group_e;
endpackage

// File: rtl/jcu_cond_eval.sv
// Condition evaluator: maps a 4-bit condition code and the flags to a hit bit.
// Assumes the flags reflect the last compare/subtract. Groups beyond
// CG_SLE are reserved and never hit, whatever the negate bit says.
module jcu_cond_eval
    import jcu_pkg::*;
#(
    parameter int CW = COND_W
) (
    input  logic [CW-1:0] cond,
    input  logic          zf,
    input  logic          cf,
    input  logic          sf,
    input  logic          ovf,
    output logic          hit
);
    logic        base;
    logic        legal;
    logic        sign_ne;
    cond_group_e grp;

    assign sign_ne = sf ^ ovf;
    assign grp     = cond_group_e'(cond[CW-1:1]);

    // Pick the base predicate for the group and flag reserved groups
    always_comb begin
        base  = 1'b0;
        legal = 1'b1;
        case (grp)
            CG_ZERO:  base = zf;
            CG_CARRY: base = cf;
            CG_ULE:   base = cf | zf;
            CG_SLT:   base = sign_ne;
            CG_SLE:   base = zf | sign_ne;
            default:  legal = 1'b0;
        endcase
    end

    assign hit = legal & (base ^ cond[0]);
endmodule

// File: rtl/jcu_target_calc.sv
// Target adder: sign-extends the short offset or uses the full offset
// and adds it to the advanced instruction pointer, wrapping modulo 2^AW.
// Assumes imm[7:0] holds the first-fetched (low) offset byte.
module jcu_target_calc
    import jcu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SHORT_W
) (
    input  logic [AW-1:0] ip,
    input  logic [AW-1:0] imm,
    input  logic          use_full,
    output logic [AW-1:0] target
);
    localparam int EXT_W = AW - SW;

    logic [AW-1:0] short_ext;
    logic [AW-1:0] offset;

    generate
        if (EXT_W > 0) begin : g_ext
            assign short_ext = {{EXT_W{imm[SW-1]}}, imm[SW-1:0]};
        end else begin : g_noext
            assign short_ext = imm;
        end
    endgenerate

    assign offset = use_full ? imm : short_ext;
    assign target = ip + offset;
endmodule

// File: rtl/jcu_top.sv
// Relative jump and condition unit, top level.
// Registers the taken decision and the next pointer one cycle after inputs.
// Assumes ip_i already points past the whole jump instruction.
module jcu_top
    import jcu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SHORT_W,
    parameter int CW = COND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ip_i,
    input  logic          kind_i,
    input  logic [CW-1:0] cond_i,
    input  logic [AW-1:0] imm_i,
    input  logic          zf_i,
    input  logic          cf_i,
    input  logic          sf_i,
    input  logic          of_i,
    output logic          taken_o,
    output logic [AW-1:0] next_ip_o
);
    logic          cond_hit;
    logic          is_full;
    logic          take_d;
    logic [AW-1:0] target;
    logic [AW-1:0] next_d;

    assign is_full = (jump_kind_e'(kind_i) == JK_NEAR_ALWAYS);

    jcu_cond_eval #(.CW(CW)) u_cond (
        .cond (cond_i),
        .zf   (zf_i),
        .cf   (cf_i),
        .sf   (sf_i),
        .ovf  (of_i),
        .hit  (cond_hit)
    );

    jcu_target_calc #(.AW(AW), .SW(SW)) u_tgt (
        .ip       (ip_i),
        .imm      (imm_i),
        .use_full (is_full),
        .target   (target)
    );

    assign take_d = is_full | cond_hit;
    assign next_d = take_d ? target : ip_i;

    // Register the decision and pointer; synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            next_ip_o <= '0;
        end else begin
            taken_o   <= take_d;
            next_ip_o <= next_d;
        end
    end
endmodule

// File: rtl/jcu_chk.sv
// Property checker for jcu_top, relating registered outputs to the
// inputs of the previous cycle. Attached with the bind below.
module jcu_chk #(
    parameter int AW = 16,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ip_i,
    input logic          kind_i,
    input logic [CW-1:0] cond_i,
    input logic [AW-1:0] imm_i,
    input logic          zf_i,
    input logic          cf_i,
    input logic          sf_i,
    input logic          of_i,
    input logic          taken_o,
    input logic [AW-1:0] next_ip_o
);
    // R3
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i)) |-> (taken_o && next_ip_o == AW'($past(ip_i) + $past(imm_i))));

    // R4
    short_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(kind_i) && taken_o) |->
        (next_ip_o == AW'($past(ip_i) + {{(AW-8){$past(imm_i[7])}}, $past(imm_i[7:0])})));

    // R5
    not_taken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> (next_ip_o == $past(ip_i)));

    // R10
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(kind_i) && $past(cond_i) >= CW'(10)) |-> !taken_o);

    // R6
    equal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(kind_i) && $past(cond_i) == CW'(0)) |-> (taken_o == $past(zf_i)));
endmodule

bind jcu_top jcu_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/jcu_top_bench.sv
// Directed bench for jcu_top: one task per scenario, each self-checking.
module jcu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ip_i = '0;
    logic        kind_i = 1'b0;
    logic [3:0]  cond_i = '0;
    logic [15:0] imm_i = '0;
    logic        zf_i = 1'b0, cf_i = 1'b0, sf_i = 1'b0, of_i = 1'b0;
    logic        taken_o;
    logic [15:0] next_ip_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    jcu_top u_jcu_top (.*);

    // Check one taken/pointer pair against expectation
    task automatic expect_out(input string tag, input logic et, input logic [15:0] eip);
        checks++;
        if (taken_o !== et || next_ip_o !== eip) begin
            errors++;
            $display("FAIL %s: taken=%0b next=%04h expected taken=%0b next=%04h",
                     tag, taken_o, next_ip_o, et, eip);
        end
    endtask

    // Drive one set of inputs on a falling edge; results sampled after next rise
    task automatic drive(input logic k, input logic [3:0] c, input logic [15:0] ip,
                         input logic [15:0] imm, input logic [3:0] fl);
        @(negedge clk);
        kind_i = k; cond_i = c; ip_i = ip; imm_i = imm;
        {zf_i, cf_i, sf_i, of_i} = fl;
        @(posedge clk);
        #1;
    endtask

    // Bench model of the condition table, written from R6..R10
    function automatic logic model_hit(input logic [3:0] c, input logic [3:0] fl);
        logic z, cy, s, o, b;
        {z, cy, s, o} = fl;
        case (c[3:1])
            3'd0: b = z;
            3'd1: b = cy;
            3'd2: b = cy | z;
            3'd3: b = (s != o);
            3'd4: b = z | (s != o);
            default: return 1'b0;
        endcase
        return b ^ c[0];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b1, 4'd0, 16'h1234, 16'h0001, 4'hF);
        expect_out("R1 reset", 1'b0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_always();
        drive(1'b1, 4'd0, 16'h0037, 16'h0010, 4'h0);
        expect_out("R3 forward", 1'b1, 16'h0047);
        drive(1'b1, 4'd11, 16'h0100, 16'hFFF0, 4'h0);
        expect_out("R3 backward", 1'b1, 16'h00F0);
        drive(1'b1, 4'd0, 16'hFFF0, 16'h0020, 4'h0);
        expect_out("R11 wrap forward", 1'b1, 16'h0010);
    endtask

    task automatic t_latency();
        drive(1'b1, 4'd0, 16'h0200, 16'h0002, 4'h0);
        @(negedge clk);
        kind_i = 1'b0; cond_i = 4'd1; ip_i = 16'h0300; zf_i = 1'b1;
        #1;
        expect_out("R2 hold before edge", 1'b1, 16'h0202);
        @(posedge clk);
        #1;
        expect_out("R2 update after edge", 1'b0, 16'h0300);
    endtask

    task automatic t_short();
        drive(1'b0, 4'd0, 16'h0200, 16'h1280, 4'b1000);
        expect_out("R4 -128 upper ignored", 1'b1, 16'h0180);
        drive(1'b0, 4'd0, 16'h0200, 16'hAB7F, 4'b1000);
        expect_out("R4 +127", 1'b1, 16'h027F);
        drive(1'b0, 4'd0, 16'h0005, 16'h00F0, 4'b1000);
        expect_out("R11 wrap backward", 1'b1, 16'hFFF5);
        drive(1'b0, 4'd0, 16'h4321, 16'h0040, 4'b0000);
        expect_out("R5 not taken", 1'b0, 16'h4321);
    endtask

    task automatic t_compare();
        // 7FFFh - 8000h: ZF=0 CF=1 SF=1 OF=1
        drive(1'b0, 4'd5, 16'h0800, 16'h0010, 4'b0111);
        expect_out("R7 above false", 1'b0, 16'h0800);
        drive(1'b0, 4'd9, 16'h0800, 16'h0010, 4'b0111);
        expect_out("R8 greater true", 1'b1, 16'h0810);
    endtask

    task automatic t_sweep();
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic e;
                e = model_hit(4'(c), 4'(f));
                drive(1'b0, 4'(c), 16'h1000, 16'h0004, 4'(f));
                if (c < 2)       expect_out("R6 zero group", e, e ? 16'h1004 : 16'h1000);
                else if (c < 4)  expect_out("R6 carry group", e, e ? 16'h1004 : 16'h1000);
                else if (c < 6)  expect_out("R7 unsigned group", e, e ? 16'h1004 : 16'h1000);
                else if (c < 10) expect_out("R8 signed group", e, e ? 16'h1004 : 16'h1000);
                else             expect_out("R10 reserved", 1'b0, 16'h1000);
            end
        end
    endtask

    task automatic t_negate();
        for (int c = 0; c < 10; c += 2) begin
            for (int f = 0; f < 16; f++) begin
                logic a;
                drive(1'b0, 4'(c), 16'h2000, 16'h0008, 4'(f));
                a = taken_o;
                drive(1'b0, 4'(c + 1), 16'h2000, 16'h0008, 4'(f));
                checks++;
                if (taken_o === a) begin
                    errors++;
                    $display("FAIL R9 code %0d flags %h: taken=%0b expected %0b", c + 1, f, taken_o, !a);
                end
            end
        end
    endtask

    initial begin
        t_reset();
        t_always();
        t_latency();
        t_short();
        t_compare();
        t_sweep();
        t_negate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule